// File: doc/BRIEF.md
# Input Stream Control and Status Engine

This block holds the control and status word of a single inbound sample stream and owns the small receive FIFO that sits in front of the stream's memory mover. Software programs the word through a 32-bit register port. It sets the run bit and the interrupt enables, and it acknowledges events by writing ones to the status bits. Hardware sets the status bits when a descriptor has been loaded, when a descriptor fetch fails, when the FIFO overflows, and when a buffer flagged for completion notice has finished.

Samples arrive on a valid/data stream and are stored only while the stream runs. The downstream mover drains them through a first-word-fall-through read port. A failed descriptor fetch is fatal and stops the stream without software help. An overflow discards the incoming sample and leaves the FIFO untouched, and it records the event even when that interrupt is masked. A stream reset bit flushes the FIFO and holds all run and status state at zero.

Top module: `instream_ctl`

## Requirements
- R1: After reset the register reads 0x00040000, and bits 31:30, 25:24 and 15:5 always read zero.
- R2: Writes store stream reset (bit 0), run (bit 1), completion enable (bit 2), overflow enable (bit 3), descriptor-error enable (bit 4), a 2-bit stripe field (17:16), a priority bit (18, reset 1), a direction bit (19) and a 4-bit stream number (23:20), and these read back as written.
- R3: The ready flag (bit 29) sets on a descriptor-load pulse, clears on a descriptor-error pulse (the error wins if both pulses arrive together), and ignores register writes.
- R4: A descriptor-error pulse sets bit 28 and clears run on the same edge. Run cannot be set while bit 28 stays set. Writing 1 to bit 28 clears it, and the same write may set run.
- R5: A valid sample that arrives while run is 1 and the FIFO holds 16 entries is discarded, and the FIFO count stays the same. Bit 27 sets whatever the state of its enable, and writing 1 to bit 27 clears it.
- R6: Samples that arrive while run is 0 are not stored and do not set bit 27.
- R7: An end-of-buffer pulse sets bit 26 only when its completion flag is 1. Writing 1 to bit 26 clears it.
- R8: When a hardware set and a write-one-clear reach the same status bit in the same cycle, the bit ends up set.
- R9: The interrupt output is high exactly when bit 26, 27 or 28 is set together with its enable (bit 2, 3 or 4 respectively).
- R10: While stream reset is 1, the FIFO is emptied, run and bits 26 to 29 are held at zero, and any events that arrive are lost.
- R11: The FIFO returns samples in arrival order. The head entry is presented before it is popped, the empty flag is accurate, and a pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| desc_load | input | 1 | Descriptor loaded pulse |
| desc_err | input | 1 | Descriptor fetch error pulse |
| buf_end | input | 1 | Last sample of a buffer processed |
| buf_ioc | input | 1 | Completion-notice flag of that buffer |
| smp_valid | input | 1 | Incoming sample valid |
| smp_data | input | DW | Incoming sample |
| fifo_rd | input | 1 | Pop the FIFO head |
| fifo_dout | output | DW | FIFO head sample |
| fifo_empty | output | 1 | FIFO holds no samples |
| run_o | output | 1 | Stream run state |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the FIFO and keeps pushing, to catch a design that overwrites the oldest entry or moves its write pointer on a full FIFO, which would show up as corrupted read order. It issues a clear of the overflow and completion bits in the same cycle as a new event, so a design that lets the clear win loses an event. It raises a descriptor error while the stream runs and then tries to set run again before acknowledging it, which exposes a design that leaves the stream running after a fatal error. It also sends descriptor, completion and sample events while the stream is in reset, where a leaky reset would leave stale status or data behind.

// File: rtl/instream_ctl.sv
module instream_ctl #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          desc_load,
  input  logic          desc_err,
  input  logic          buf_end,
  input  logic          buf_ioc,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          fifo_rd,
  output logic [DW-1:0] fifo_dout,
  output logic          fifo_empty,
  output logic          run_o,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          srst_q, run_q, ie_done_q, ie_ovf_q, ie_derr_q;
  logic [1:0]    stripe_q;
  logic          prio_q, dir_q;
  logic [3:0]    sid_q;
  logic          ready_q, derr_q, ovf_q, done_q;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  wire full     = (cnt == CW'(DEPTH));
  wire push_req = smp_valid & run_q & ~srst_q;
  wire push_ok  = push_req & ~full;
  wire ovf_hit  = push_req & full;
  wire pop_ok   = fifo_rd & ~fifo_empty & ~srst_q;
  wire done_hit = buf_end & buf_ioc;

  wire derr_n = desc_err | (derr_q & ~(reg_wr & reg_wdata[28]));
  wire ovf_n  = ovf_hit  | (ovf_q  & ~(reg_wr & reg_wdata[27]));
  wire done_n = done_hit | (done_q & ~(reg_wr & reg_wdata[26]));
  wire run_n  = (reg_wr ? reg_wdata[1] : run_q) & ~derr_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0; ie_done_q <= 1'b0; ie_ovf_q <= 1'b0; ie_derr_q <= 1'b0;
      stripe_q <= 2'd0; prio_q <= 1'b1; dir_q <= 1'b0; sid_q <= 4'd0;
    end else if (reg_wr) begin
      srst_q    <= reg_wdata[0];
      ie_done_q <= reg_wdata[2];
      ie_ovf_q  <= reg_wdata[3];
      ie_derr_q <= reg_wdata[4];
      stripe_q  <= reg_wdata[17:16];
      prio_q    <= reg_wdata[18];
      dir_q     <= reg_wdata[19];
      sid_q     <= reg_wdata[23:20];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; ready_q <= 1'b0; derr_q <= 1'b0; ovf_q <= 1'b0; done_q <= 1'b0;
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
    end else if (srst_q) begin
      run_q <= 1'b0; ready_q <= 1'b0; derr_q <= 1'b0; ovf_q <= 1'b0; done_q <= 1'b0;
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
    end else begin
      run_q   <= run_n;
      derr_q  <= derr_n;
      ovf_q   <= ovf_n;
      done_q  <= done_n;
      ready_q <= ~desc_err & (desc_load | ready_q);
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= smp_data;
  end

  assign fifo_empty = (cnt == '0);
  assign fifo_dout  = mem[rd_ptr];
  assign run_o      = run_q;
  assign irq        = (done_q & ie_done_q) | (ovf_q & ie_ovf_q) | (derr_q & ie_derr_q);
  assign reg_rdata  = {2'b00, ready_q, derr_q, ovf_q, done_q, 2'b00, sid_q, dir_q, prio_q,
                       stripe_q, 11'd0, ie_derr_q, ie_ovf_q, ie_done_q, run_q, srst_q};

  p_derr_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    derr_q |-> !run_q);
  p_drop_on_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !pop_ok) |=> (cnt == $past(cnt)) && ovf_q);
  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && !srst_q) |=> done_q);
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_q || ovf_q || derr_q));
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (cnt == '0) && !run_q && !ready_q && !derr_q && !ovf_q && !done_q);
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: tb/test_instream_ctl.sv
module test_instream_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, desc_load = 0, desc_err = 0, buf_end = 0, buf_ioc = 0;
  logic smp_valid = 0, fifo_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [15:0] smp_data = '0;
  logic [31:0] reg_rdata;
  logic [15:0] fifo_dout;
  logic fifo_empty, run_o, irq;

  int checks = 0, fails = 0;
  string phase = "R1 reset";

  instream_ctl #(.DW(16), .DEPTH(16)) i_instream_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_load(desc_load), .desc_err(desc_err), .buf_end(buf_end), .buf_ioc(buf_ioc),
    .smp_valid(smp_valid), .smp_data(smp_data), .fifo_rd(fifo_rd), .fifo_dout(fifo_dout),
    .fifo_empty(fifo_empty), .run_o(run_o), .irq(irq));

  always #4 clk = ~clk;

  // behavioural reference
  bit m_srst, m_run, m_ied, m_ieo, m_iee, m_prio, m_dir, m_rdy, m_derr, m_ovf, m_done;
  bit [1:0] m_stripe;
  bit [3:0] m_sid;
  logic [15:0] q[$];

  function automatic logic [31:0] exp_reg();
    logic [31:0] v = '0;
    v[0] = m_srst; v[1] = m_run; v[2] = m_ied; v[3] = m_ieo; v[4] = m_iee;
    v[17:16] = m_stripe; v[18] = m_prio; v[19] = m_dir; v[23:20] = m_sid;
    v[26] = m_done; v[27] = m_ovf; v[28] = m_derr; v[29] = m_rdy;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_srst, m_run, m_ied, m_ieo, m_iee, m_dir, m_rdy, m_derr, m_ovf, m_done} = '0;
      m_prio = 1; m_stripe = 0; m_sid = 0; q.delete();
    end else begin
      bit nd, no, ndn, nr, nrun, popit, pushit;
      if (m_srst) begin
        {m_run, m_rdy, m_derr, m_ovf, m_done} = '0; q.delete();
      end else begin
        pushit = smp_valid && m_run && q.size() < 16;
        no  = (smp_valid && m_run && q.size() == 16) || (m_ovf && !(reg_wr && reg_wdata[27]));
        popit = fifo_rd && q.size() > 0;
        nd  = desc_err || (m_derr && !(reg_wr && reg_wdata[28]));
        ndn = (buf_end && buf_ioc) || (m_done && !(reg_wr && reg_wdata[26]));
        nr  = desc_err ? 0 : (desc_load ? 1 : m_rdy);
        nrun = (reg_wr ? reg_wdata[1] : m_run) && !nd;
        if (popit) void'(q.pop_front());
        if (pushit) q.push_back(smp_data);
        m_derr = nd; m_ovf = no; m_done = ndn; m_rdy = nr; m_run = nrun;
      end
      if (reg_wr) begin
        m_srst = reg_wdata[0]; m_ied = reg_wdata[2]; m_ieo = reg_wdata[3]; m_iee = reg_wdata[4];
        m_stripe = reg_wdata[17:16]; m_prio = reg_wdata[18]; m_dir = reg_wdata[19];
        m_sid = reg_wdata[23:20];
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("reg", reg_rdata, exp_reg());
    chk("run", 32'(run_o), 32'(m_run));
    chk("irq", 32'(irq), 32'((m_done & m_ied) | (m_ovf & m_ieo) | (m_derr & m_iee)));
    chk("empty", 32'(fifo_empty), 32'(q.size() == 0));
    if (q.size() > 0) chk("dout", 32'(fifo_dout), 32'(q[0]));
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; cyc(); reg_wr = 0;
  endtask
  task automatic push_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin smp_valid = 1; smp_data = 16'(base + i); cyc(); end
    smp_valid = 0;
  endtask
  task automatic pop_n(input int n);
    fifo_rd = 1; repeat (n) cyc(); fifo_rd = 0;
  endtask

  localparam logic [31:0] CFG = 32'h00FF001C;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc();
    chk("R1 reset reg", reg_rdata, 32'h00040000);
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset empty", 32'(fifo_empty), 1);
    rst_n = 1; cyc(); cyc();
    phase = "R2 config"; wr(32'hC3FFFFFC); cyc();
    chk("R2 readback", reg_rdata, CFG);
    phase = "R3 ready"; desc_load = 1; cyc(); desc_load = 0;
    wr(CFG | 32'h2000_0000); cyc();
    chk("R3 ready held", 32'(reg_rdata[29]), 1);
    desc_load = 1; desc_err = 1; cyc(); desc_load = 0; desc_err = 0;
    wr(CFG | 32'h1000_0000); desc_load = 1; cyc(); desc_load = 0;
    phase = "R5 overrun"; wr(CFG | 2); push_n(20, 100); cyc();
    chk("R5 ovf set", 32'(reg_rdata[27]), 1);
    phase = "R11 fifo order"; pop_n(18); cyc();
    chk("R11 empty", 32'(fifo_empty), 1);
    phase = "R8 set wins"; push_n(16, 300);
    smp_valid = 1; smp_data = 16'hBEEF; wr(CFG | 2 | 32'h0800_0000); smp_valid = 0; cyc();
    chk("R8 ovf kept", 32'(reg_rdata[27]), 1);
    phase = "R5 clear"; wr(CFG | 2 | 32'h0800_0000); pop_n(16); cyc();
    phase = "R6 stopped"; wr(CFG); push_n(5, 500); cyc();
    chk("R6 empty", 32'(fifo_empty), 1);
    phase = "R7 completion"; buf_end = 1; cyc(); buf_end = 0; cyc();
    chk("R7 no ioc", 32'(reg_rdata[26]), 0);
    buf_end = 1; buf_ioc = 1; cyc(); buf_end = 0; buf_ioc = 0; cyc();
    phase = "R8 done set wins"; buf_end = 1; buf_ioc = 1; wr(CFG | 32'h0400_0000);
    buf_end = 0; buf_ioc = 0; cyc();
    phase = "R9 irq gating";
    wr(CFG & ~32'h1C); cyc(); wr(CFG & ~32'h18); cyc(); wr(CFG | 32'h0400_0000); cyc();
    phase = "R4 desc error"; wr(CFG | 2); desc_err = 1; cyc(); desc_err = 0; cyc();
    chk("R4 run cleared", 32'(run_o), 0);
    wr(CFG | 2); cyc(); wr(CFG & ~32'h10 | 2); cyc();
    wr(CFG | 2 | 32'h1000_0000); cyc();
    chk("R4 restart", 32'(run_o), 1);
    phase = "R10 stream reset"; desc_load = 1; cyc(); desc_load = 0;
    push_n(6, 700); buf_end = 1; buf_ioc = 1; cyc(); buf_end = 0; buf_ioc = 0;
    wr(CFG | 3); desc_load = 1; buf_end = 1; buf_ioc = 1; desc_err = 1; smp_valid = 1;
    cyc(); cyc();
    desc_load = 0; buf_end = 0; buf_ioc = 0; desc_err = 0; smp_valid = 0;
    wr(CFG | 2); cyc(); cyc();
    chk("R10 flushed", 32'(fifo_empty), 1);
    chk("R10 status", reg_rdata & 32'h3C00_0002, 0);
    phase = "R11 after reset"; wr(CFG | 2); push_n(3, 900); pop_n(4); cyc();
    finish_run();
  end
endmodule